// File: doc/BRIEF.md
# Forty-Bit Multiply-Accumulate Execution Unit with Result Interlock

This unit sits in the execute stage of a 32-bit integer pipeline and carries out multiply-accumulate operations. It takes the low 16-bit half of each of the two source operands and multiplies the halves as unsigned or as two's-complement values, as an opcode bit selects. The product goes into a 40-bit running sum. The sum is stored in two architectural registers. The upper 8 bits sit in the low byte of an auxiliary register called the extension register. The lower 32 bits sit in a register of their own called the low accumulator. The low 32 bits of every new sum also go back to the general register file, through a registered write-back port.

An operation issues in a single cycle, but the register file can only use its result two cycles later. Suppose the instruction that follows a multiply-accumulate reads that operation's destination register. A small state machine then holds this instruction for exactly one cycle: a state `HZ_IDLE` (no result in flight), a state `HZ_PEND` (an operation issued in the last cycle) and a state `HZ_HOLD` (the consumer is being held for its single stall cycle). The transitions are:
- issue: from `HZ_IDLE` or `HZ_HOLD` to `HZ_PEND`, and `HZ_PEND` to itself.
- hit: from `HZ_PEND` to `HZ_HOLD`.
- drain: from `HZ_PEND` or `HZ_HOLD` to `HZ_IDLE`, when nothing issues.

Software reads both accumulator registers at any time, and it writes either one through its own write strobe.

Top module: `mac40_unit`

## Requirements
- R1: With `slot_signed`=0 the operation multiplies `opnd_a[15:0]` by `opnd_b[15:0]` as unsigned numbers. It ignores bits [31:16] of both operands and adds the product, zero-extended, to the 40-bit sum {`y_q[7:0]`, `acc_lo_q`}.
- R2: With `slot_signed`=1 both 16-bit halves are two's-complement. The product is sign-extended to 40 bits before the addition, and the sum wraps modulo 2^40.
- R3: At the clock edge that ends the issue cycle, `acc_lo_q` takes sum[31:0] and `y_q[7:0]` takes sum[39:32]. `wb_data` carries sum[31:0].
- R4: `wb_valid` is 1 in the cycle after an issue, with `wb_idx` equal to the issued `slot_rd`. In every other cycle it is 0.
- R5: An operation leaves `y_q[31:8]` unchanged.
- R6: An instruction can depend on the operation issued in the previous cycle. It does so if its `slot_rs1` equals that operation's `slot_rd`, or if `slot_uses_b`=1 and its `slot_rs2` equals that `slot_rd`. In that case `stall` is 1 for exactly one cycle, and the held instruction is accepted in the next cycle. A held operation does not change the sum.
- R7: `stall` stays 0 in four cases: no operation issued in the previous cycle, the index does not match, the only match is on `slot_rs2` while `slot_uses_b`=0, or the slot is empty.
- R8: `acc_lo_we` loads `acc_lo_wdata` into `acc_lo_q`, and `y_we` loads `y_wdata` into all 32 bits of `y_q`. Each write is visible after that clock edge.
- R9: A software write and an issue can fall in the same cycle. The operation's update then wins, and both software writes of that cycle are dropped.
- R10: Reset makes both accumulator registers zero, drops `wb_valid` and `stall`, and puts the state machine in `HZ_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_valid | input | 1 | The issue slot holds an instruction |
| slot_mac | input | 1 | The slot instruction is a multiply-accumulate |
| slot_signed | input | 1 | 1 selects signed multiply, 0 unsigned |
| slot_uses_b | input | 1 | Second source is a register (0: immediate) |
| slot_rs1 | input | 5 | First source register index |
| slot_rs2 | input | 5 | Second source register index |
| slot_rd | input | 5 | Destination register index |
| opnd_a | input | 32 | First operand value |
| opnd_b | input | 32 | Second operand value |
| acc_lo_we | input | 1 | Software write strobe, low accumulator |
| acc_lo_wdata | input | 32 | Software write data, low accumulator |
| y_we | input | 1 | Software write strobe, extension register |
| y_wdata | input | 32 | Software write data, extension register |
| acc_lo_q | output | 32 | Low accumulator contents |
| y_q | output | 32 | Extension register contents |
| wb_valid | output | 1 | Result write-back strobe |
| wb_idx | output | 5 | Result destination index |
| wb_data | output | 32 | Result data |
| stall | output | 1 | Hold the instruction in the issue slot |

## Verification
The assertions check five relations on every cycle:
- a stall never lasts two cycles, and it only follows an issue;
- every issue produces a write-back to the right index in the next cycle;
- the write-back data agrees with the new low accumulator;
- an issue keeps the upper extension bits;
- a software write that meets no issue lands.

The arithmetic itself, with operand halves, sign extension and wraparound at 2^40, can only be shown by the bench's directed scenarios against its own model. The same holds for which index matches do or do not stall, and for the priority of an issue over a same-cycle software write.

// File: rtl/mac40_pkg.sv
package mac40_pkg;

    // Interlock tracker states
    typedef enum logic [1:0] {
        HZ_IDLE = 2'd0,
        HZ_PEND = 2'd1,
        HZ_HOLD = 2'd2
    } hz_state_t;

endpackage

// File: rtl/mac40_mult.sv
// Multiplies the low halves of two operands and extends the product to
// the accumulator width. A shared extension bit makes one signed
// multiplier serve both the unsigned and the signed variant.
module mac40_mult #(
    parameter int OPW   = 32,
    parameter int HALFW = 16,
    parameter int ACCW  = 40
) (
    input  logic            is_signed_i,
    input  logic [OPW-1:0]  a_i,
    input  logic [OPW-1:0]  b_i,
    output logic [ACCW-1:0] prod_o
);
    localparam int FW = 2 * (HALFW + 1);

    logic signed [HALFW:0] ea;
    logic signed [HALFW:0] eb;
    logic signed [FW-1:0]  full;

    always_comb begin
        ea     = {is_signed_i & a_i[HALFW-1], a_i[HALFW-1:0]};
        eb     = {is_signed_i & b_i[HALFW-1], b_i[HALFW-1:0]};
        full   = ea * eb;
        prod_o = {{(ACCW-FW){full[FW-1]}}, full};
    end
endmodule

// File: rtl/mac40_acc.sv
// The two architectural registers that hold the running sum.
module mac40_acc #(
    parameter int OPW  = 32,
    parameter int ACCW = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_i,
    input  logic [ACCW-1:0] sum_i,
    input  logic            lo_we_i,
    input  logic [OPW-1:0]  lo_wdata_i,
    input  logic            y_we_i,
    input  logic [OPW-1:0]  y_wdata_i,
    output logic [ACCW-1:0] acc_o,
    output logic [OPW-1:0]  lo_q_o,
    output logic [OPW-1:0]  y_q_o
);
    localparam int HIW = ACCW - OPW;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q_o <= '0;
            y_q_o  <= '0;
        end else if (upd_i) begin
            lo_q_o          <= sum_i[OPW-1:0];
            y_q_o[HIW-1:0]  <= sum_i[ACCW-1:OPW];
        end else begin
            if (lo_we_i) lo_q_o <= lo_wdata_i;
            if (y_we_i)  y_q_o  <= y_wdata_i;
        end
    end

    assign acc_o = {y_q_o[HIW-1:0], lo_q_o};
endmodule

// File: rtl/mac40_hazard.sv
// Tracks the result in flight and holds a dependent successor one cycle.
module mac40_hazard
    import mac40_pkg::*;
#(
    parameter int IDXW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_i,
    input  logic [IDXW-1:0] rd_i,
    input  logic            slot_valid_i,
    input  logic            uses_b_i,
    input  logic [IDXW-1:0] rs1_i,
    input  logic [IDXW-1:0] rs2_i,
    output logic            stall_o
);
    hz_state_t       state_q, state_d;
    logic [IDXW-1:0] pend_rd_q;
    logic            hit;

    always_comb begin
        hit = slot_valid_i &&
              ((rs1_i == pend_rd_q) || (uses_b_i && (rs2_i == pend_rd_q)));
    end

    // State register and pending destination
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= HZ_IDLE;
            pend_rd_q <= '0;
        end else begin
            state_q <= state_d;
            if (issue_i) pend_rd_q <= rd_i;
        end
    end

    // Next state
    always_comb begin
        state_d = HZ_IDLE;
        unique case (state_q)
            HZ_IDLE: state_d = issue_i ? HZ_PEND : HZ_IDLE;
            HZ_PEND: begin
                if (hit)          state_d = HZ_HOLD;
                else if (issue_i) state_d = HZ_PEND;
                else              state_d = HZ_IDLE;
            end
            HZ_HOLD: state_d = issue_i ? HZ_PEND : HZ_IDLE;
            default: state_d = HZ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        stall_o = 1'b0;
        unique case (state_q)
            HZ_PEND: stall_o = hit;
            HZ_IDLE, HZ_HOLD: stall_o = 1'b0;
            default: stall_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/mac40_unit.sv
module mac40_unit #(
    parameter int OPW   = 32,
    parameter int HALFW = 16,
    parameter int ACCW  = 40,
    parameter int IDXW  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slot_valid,
    input  logic            slot_mac,
    input  logic            slot_signed,
    input  logic            slot_uses_b,
    input  logic [IDXW-1:0] slot_rs1,
    input  logic [IDXW-1:0] slot_rs2,
    input  logic [IDXW-1:0] slot_rd,
    input  logic [OPW-1:0]  opnd_a,
    input  logic [OPW-1:0]  opnd_b,
    input  logic            acc_lo_we,
    input  logic [OPW-1:0]  acc_lo_wdata,
    input  logic            y_we,
    input  logic [OPW-1:0]  y_wdata,
    output logic [OPW-1:0]  acc_lo_q,
    output logic [OPW-1:0]  y_q,
    output logic            wb_valid,
    output logic [IDXW-1:0] wb_idx,
    output logic [OPW-1:0]  wb_data,
    output logic            stall
);
    logic            issue;
    logic [ACCW-1:0] prod;
    logic [ACCW-1:0] acc;
    logic [ACCW-1:0] sum;

    assign issue = slot_valid & slot_mac & ~stall;
    assign sum   = acc + prod;

    mac40_mult #(.OPW(OPW), .HALFW(HALFW), .ACCW(ACCW)) u_mult (
        .is_signed_i (slot_signed),
        .a_i         (opnd_a),
        .b_i         (opnd_b),
        .prod_o      (prod)
    );

    mac40_acc #(.OPW(OPW), .ACCW(ACCW)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_i      (issue),
        .sum_i      (sum),
        .lo_we_i    (acc_lo_we),
        .lo_wdata_i (acc_lo_wdata),
        .y_we_i     (y_we),
        .y_wdata_i  (y_wdata),
        .acc_o      (acc),
        .lo_q_o     (acc_lo_q),
        .y_q_o      (y_q)
    );

    mac40_hazard #(.IDXW(IDXW)) u_hz (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_i      (issue),
        .rd_i         (slot_rd),
        .slot_valid_i (slot_valid),
        .uses_b_i     (slot_uses_b),
        .rs1_i        (slot_rs1),
        .rs2_i        (slot_rs2),
        .stall_o      (stall)
    );

    // Write-back register: the result reaches the register file one cycle
    // after issue and is readable from the cycle after that.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_idx   <= '0;
            wb_data  <= '0;
        end else begin
            wb_valid <= issue;
            if (issue) begin
                wb_idx  <= slot_rd;
                wb_data <= sum[OPW-1:0];
            end
        end
    end
endmodule

// File: rtl/mac40_unit_chk.sv
module mac40_unit_chk #(
    parameter int OPW  = 32,
    parameter int IDXW = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            slot_valid,
    input logic            slot_mac,
    input logic [IDXW-1:0] slot_rd,
    input logic            acc_lo_we,
    input logic [OPW-1:0]  acc_lo_wdata,
    input logic [OPW-1:0]  acc_lo_q,
    input logic [OPW-1:0]  y_q,
    input logic            wb_valid,
    input logic [IDXW-1:0] wb_idx,
    input logic [OPW-1:0]  wb_data,
    input logic            stall
);
    logic accepted;
    assign accepted = slot_valid & slot_mac & ~stall;

    p_stall_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    p_stall_needs_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> $past(accepted));

    p_wb_after_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> (wb_valid && wb_idx == $past(slot_rd)));

    p_wb_only_after_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(accepted));

    p_wb_matches_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_data == acc_lo_q));

    p_y_upper_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> (y_q[OPW-1:8] == $past(y_q[OPW-1:8])));

    p_sw_lo_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_lo_we && !accepted) |=> (acc_lo_q == $past(acc_lo_wdata)));
endmodule

bind mac40_unit mac40_unit_chk #(.OPW(OPW), .IDXW(IDXW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_valid   (slot_valid),
    .slot_mac     (slot_mac),
    .slot_rd      (slot_rd),
    .acc_lo_we    (acc_lo_we),
    .acc_lo_wdata (acc_lo_wdata),
    .acc_lo_q     (acc_lo_q),
    .y_q          (y_q),
    .wb_valid     (wb_valid),
    .wb_idx       (wb_idx),
    .wb_data      (wb_data),
    .stall        (stall)
);

// File: tb/sim_mac40_unit.sv
module sim_mac40_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_valid = 1'b0, slot_mac = 1'b0, slot_signed = 1'b0, slot_uses_b = 1'b0;
    logic [4:0]  slot_rs1 = '0, slot_rs2 = '0, slot_rd = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic        acc_lo_we = 1'b0, y_we = 1'b0;
    logic [31:0] acc_lo_wdata = '0, y_wdata = '0;
    logic [31:0] acc_lo_q, y_q, wb_data;
    logic        wb_valid, stall;
    logic [4:0]  wb_idx;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] m_lo = '0;
    logic [31:0] m_y  = '0;

    always #2 clk = ~clk;   // 250 MHz

    mac40_unit u0 (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_slot();
        slot_valid = 0; slot_mac = 0; slot_uses_b = 0;
        acc_lo_we = 0; y_we = 0;
    endtask

    // Model of one accumulate step
    task automatic model_mac(input logic sgn, input logic [31:0] a, input logic [31:0] b,
                             output logic [39:0] s);
        longint p;
        logic [39:0] acc40;
        if (sgn) p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
        else     p = longint'(a[15:0]) * longint'(b[15:0]);
        acc40 = {m_y[7:0], m_lo};
        s = acc40 + p[39:0];
        m_lo = s[31:0];
        m_y[7:0] = s[39:32];
    endtask

    task automatic do_mac(input string req, input logic sgn, input logic [31:0] a,
                          input logic [31:0] b, input logic [4:0] rd);
        logic [39:0] s;
        slot_valid = 1; slot_mac = 1; slot_signed = sgn; slot_uses_b = 1;
        slot_rs1 = 5'd30; slot_rs2 = 5'd31; slot_rd = rd;
        opnd_a = a; opnd_b = b;
        model_mac(sgn, a, b, s);
        step();
        idle_slot();
        check({req, " wb_valid"}, 64'(wb_valid), 64'd1);
        check({req, " R4 wb_idx"}, 64'(wb_idx), 64'(rd));
        check({req, " R3 wb_data"}, 64'(wb_data), 64'(s[31:0]));
        check({req, " R3 acc_lo"}, 64'(acc_lo_q), 64'(m_lo));
        check({req, " R3 y"}, 64'(y_q), 64'(m_y));
    endtask

    task automatic sw_write(input logic [31:0] lo, input logic [31:0] y);
        acc_lo_we = 1; acc_lo_wdata = lo; y_we = 1; y_wdata = y;
        step();
        idle_slot();
        m_lo = lo; m_y = y;
        check("R8 sw lo write", 64'(acc_lo_q), 64'(lo));
        check("R8 sw y write", 64'(y_q), 64'(y));
    endtask

    task automatic t_reset();
        check("R10 reset acc_lo", 64'(acc_lo_q), 64'd0);
        check("R10 reset y", 64'(y_q), 64'd0);
        check("R10 reset wb_valid", 64'(wb_valid), 64'd0);
        check("R10 reset stall", 64'(stall), 64'd0);
    endtask

    task automatic t_unsigned();
        do_mac("R1 unsigned small", 0, 32'hABCD_0003, 32'h1234_0005, 5'd3);
        do_mac("R1 unsigned max", 0, 32'h0000_FFFF, 32'hFFFF_FFFF, 5'd4);
        do_mac("R1 unsigned max again", 0, 32'h5555_FFFF, 32'h0000_FFFF, 5'd5);
        step();
        check("R4 no wb when idle", 64'(wb_valid), 64'd0);
    endtask

    task automatic t_signed();
        sw_write(32'd0, 32'd0);
        do_mac("R2 signed neg*pos", 1, 32'h0000_FFFE, 32'h0000_0007, 5'd6);
        check("R2 sign-extended upper byte", 64'(y_q[7:0]), 64'hFF);
        do_mac("R2 signed neg*neg", 1, 32'hFFFF_8000, 32'h0000_8000, 5'd7);
        sw_write(32'hFFFF_FFF0, 32'h0000_00FF);
        do_mac("R2 wrap at 2^40", 0, 32'h0000_0004, 32'h0000_0008, 5'd8);
        check("R2 wrapped to 0x10", 64'({y_q[7:0], acc_lo_q}), 64'h10);
    endtask

    task automatic t_y_upper();
        sw_write(32'h1111_1111, 32'hA5A5_A5FF);
        do_mac("R5 y upper", 1, 32'h0000_7FFF, 32'h0000_7FFF, 5'd9);
        check("R5 y[31:8] kept", 64'(y_q[31:8]), 64'h00A5_A5A5);
    endtask

    task automatic t_stall_rs1();
        do_mac("R6 producer", 0, 32'd2, 32'd3, 5'd12);
        slot_valid = 1; slot_mac = 0; slot_rs1 = 5'd12; slot_rs2 = 5'd1; slot_uses_b = 0;
        #1;
        check("R6 stall on rs1 match", 64'(stall), 64'd1);
        step();
        check("R6 stall lasts one cycle", 64'(stall), 64'd0);
        idle_slot();
        step();
    endtask

    task automatic t_stall_mac_chain();
        logic [31:0] lo_before;
        logic [39:0] s;
        do_mac("R6 chain producer", 0, 32'd5, 32'd5, 5'd14);
        lo_before = acc_lo_q;
        slot_valid = 1; slot_mac = 1; slot_signed = 0; slot_uses_b = 1;
        slot_rs1 = 5'd2; slot_rs2 = 5'd14; slot_rd = 5'd15;
        opnd_a = 32'd7; opnd_b = 32'd9;
        #1;
        check("R6 stall on rs2 match", 64'(stall), 64'd1);
        step();
        check("R6 held op no update", 64'(acc_lo_q), 64'(lo_before));
        check("R6 held op no wb", 64'(wb_valid), 64'd0);
        check("R6 stall released", 64'(stall), 64'd0);
        model_mac(0, 32'd7, 32'd9, s);
        step();
        idle_slot();
        check("R6 held op then issues", 64'(acc_lo_q), 64'(m_lo));
        check("R6 held op wb_idx", 64'(wb_idx), 64'd15);
        step();
    endtask

    task automatic t_no_stall();
        do_mac("R7 producer", 0, 32'd1, 32'd1, 5'd20);
        slot_valid = 1; slot_mac = 0; slot_rs1 = 5'd21; slot_rs2 = 5'd20; slot_uses_b = 0;
        #1;
        check("R7 rs2 match with immediate", 64'(stall), 64'd0);
        slot_rs2 = 5'd22; slot_uses_b = 1;
        #0.5;
        check("R7 different index", 64'(stall), 64'd0);
        slot_valid = 0; slot_rs1 = 5'd20;
        #0.5;
        check("R7 empty slot", 64'(stall), 64'd0);
        step();
        slot_valid = 1;
        #1;
        check("R7 dependent two cycles later", 64'(stall), 64'd0);
        idle_slot();
        step();
    endtask

    task automatic t_priority();
        logic [39:0] s;
        logic [31:0] y_old;
        sw_write(32'h0000_0100, 32'h7700_0001);
        y_old = m_y;
        slot_valid = 1; slot_mac = 1; slot_signed = 0; slot_uses_b = 1;
        slot_rs1 = 5'd1; slot_rs2 = 5'd2; slot_rd = 5'd25;
        opnd_a = 32'd16; opnd_b = 32'd16;
        acc_lo_we = 1; acc_lo_wdata = 32'hDEAD_BEEF;
        y_we = 1; y_wdata = 32'h1234_5678;
        model_mac(0, 32'd16, 32'd16, s);
        step();
        idle_slot();
        check("R9 lo takes mac sum", 64'(acc_lo_q), 64'(m_lo));
        check("R9 y upper keeps old", 64'(y_q[31:8]), 64'(y_old[31:8]));
        check("R9 y low byte from sum", 64'(y_q[7:0]), 64'(s[39:32]));
    endtask

    initial begin
        #(4 * 200000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #9;
        t_reset();
        rst_n = 1;
        step();
        t_unsigned();
        t_signed();
        t_y_upper();
        t_stall_rs1();
        t_stall_mac_chain();
        t_no_stall();
        t_priority();
        step();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule